// File: doc/BRIEF.md
# Multi-format I2S audio transmitter

This block is a clock-generating serial audio transmitter. It works as the bus controller: from a fast system clock it derives the bit clock, the word-select line and an optional master clock. Stereo PCM samples arrive on a parallel valid/ready port. The block shifts them out on a single data line, most significant bit first. A divider value sets the sample rate. Every sample frame lasts 512 divider ticks, so the master clock is always 256 times the sample rate, and the bit clock is 64 or 32 times the sample rate.

Static configuration inputs select five things: the framing format (standard I2S, left-justified, right-justified, PCM with a one-bit sync pulse, or PCM with a 13-bit sync), the data length (16, 24 or 32 bits), the channel slot width (16 or 32 bits), the idle level of the bit clock, and whether the master clock is driven. One sample pair can wait in a staging register while the previous pair is being shifted. If a frame starts and no pair is waiting, the block sends silence and raises a sticky underrun flag. Software clears that flag.

The configuration inputs must stay constant while `tx_en` is high. Dropping `tx_en` returns every line to idle and discards any staged sample.

Top module: `i2s_audio_tx`

## Requirements
- R1: While `tx_en` is low, and after reset, `sd`, `ws` and `mclk` are 0, `bclk` equals `bclk_inv`, and `smp_ready` is 0.
- R2: With `clk_div` = P, one full sample frame (one `ws` period) lasts 512*(P+1) `clk` cycles and holds 2*S bit-clock periods, where S is the channel slot width.
- R3: With `mclk_on` = 1, `mclk` makes exactly 256 periods per sample frame; with `mclk_on` = 0 it stays at 0.
- R4: `sd` and `ws` change only in the `clk` cycle where the normalised bit clock (`bclk` XOR `bclk_inv`) falls, so a receiver can sample them on its rising edge.
- R5: `fmt_sel` = 0 (standard I2S): `ws` is low for the left slot and high for the right slot. Each `ws` change comes one bit before the slot it announces, so the MSB follows the `ws` change by one bit clock. When the data fills the slot, the LSB spills into the first bit of the next slot.
- R6: `fmt_sel` = 1 (left-justified): `ws` is low for the whole left slot and high for the whole right slot, and the MSB is the first bit of each slot.
- R7: `fmt_sel` = 2 (right-justified): `ws` is the same as in R6, and the LSB sits in the last bit of each slot.
- R8: `fmt_sel` = 3 (PCM short sync) gives a single `ws` bit in the last slot of the frame, just before the left MSB. `fmt_sel` = 4 (PCM long sync) holds `ws` high for the first 13 bits of the frame. In both, data is packed as in R6. Values 5 to 7 behave as 0.
- R9: `len_sel` = 0/1/2/3 selects 16/24/32/32 data bits, taken from the low bits of each input word; higher bits are ignored. The slot is 16 bits only when `frame_wide` = 0 and `len_sel` = 0, otherwise 32. Data goes MSB first and slot bits carrying no data are 0.
- R10: With `bclk_inv` = 1 the bit clock is inverted, so its idle level is high and data changes on its rising output edge.
- R11: One sample pair is staged. `smp_ready` drops in the cycle after a handshake and stays low until that pair starts playing. Each pair plays in the order accepted, starting at the next frame boundary.
- R12: At a frame start with no staged pair, a frame of zeros is sent and `urun` is set. `urun` stays set until `urun_clr` is pulsed in a cycle with no new underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Runs the transmitter; low returns all lines to idle |
| fmt_sel | input | 3 | Framing format select |
| len_sel | input | 2 | Data length select |
| frame_wide | input | 1 | Requests 32-bit slots for 16-bit data |
| bclk_inv | input | 1 | Bit clock idle level / inversion |
| mclk_on | input | 1 | Drives the master clock |
| clk_div | input | 8 | Divider value P; one tick per P+1 cycles |
| smp_valid | input | 1 | Sample pair offered |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| smp_ready | output | 1 | Staging register free |
| urun_clr | input | 1 | Clears the underrun flag |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| mclk | output | 1 | Master clock, 256 times the sample rate |
| urun | output | 1 | Sticky underrun flag |

## Verification
The bench targets the slot boundary in standard format with 32-bit data in 32-bit slots. There the right LSB must land in bit 0 of the following frame; a design that drops it or sends the left LSB corrupts one bit per frame. Right-justified 16-bit data in a 32-bit slot and 24-bit data with a forced 32-bit slot catch a wrong offset: the stream shows up shifted by eight or sixteen positions. The two PCM syncs are compared bit by bit, so a pulse one slot early or a 12- or 14-bit long sync fails. Frame length, master clock count and the silent frame after the last sample catch a wrong divider, a wrong bit-clock ratio, and a flag that is missing or clears by itself.

// File: rtl/i2stx_pkg.sv
// Shared constants and types of the serial audio transmitter.
// Assumes a maximum sample word of 32 bits and slots of 16 or 32 bits.
package i2stx_pkg;
    localparam int SMP_W    = 32;  // widest data word and widest slot
    localparam int SLOT_W   = 6;   // slot index over a 64-bit frame
    localparam int PH_W     = 4;   // divider ticks per narrow-slot bit period = 16

    typedef enum logic [2:0] {
        FMT_STD   = 3'd0,
        FMT_LJ    = 3'd1,
        FMT_RJ    = 3'd2,
        FMT_PCM_S = 3'd3,
        FMT_PCM_L = 3'd4
    } fmt_e;
endpackage

// File: rtl/i2stx_clkgen.sv
// Clock generator: divides clk by (div+1) into ticks, and counts ticks in a
// phase counter. mclk level toggles every tick (period 2 ticks). The bit clock
// takes 8 ticks per period with 32-bit slots and 16 ticks with 16-bit slots,
// so a frame always spans 512 ticks. Assumes div and wide stay static while run.
module i2stx_clkgen
    import i2stx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wide,
    input  logic [DIV_W-1:0] div,
    output logic             bclk_lvl,
    output logic             mclk_lvl,
    output logic             fall_evt
);
    logic [DIV_W-1:0] div_cnt;
    logic [PH_W-1:0]  ph;
    logic             tick;

    assign tick = run && (div_cnt == div);

    // divider: count 0..div, restart on tick or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)              div_cnt <= '0;
        else if (!run || tick)   div_cnt <= '0;
        else                     div_cnt <= div_cnt + 1'b1;
    end

    // phase counter: advances once per tick, parked at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)      ph <= '0;
        else if (!run)   ph <= '0;
        else if (tick)   ph <= ph + 1'b1;
    end

    assign mclk_lvl = ph[0];
    assign bclk_lvl = wide ? ph[PH_W-2] : ph[PH_W-1];
    assign fall_evt = tick && (wide ? (ph[PH_W-2:0] == '1) : (ph == '1));
endmodule

// File: rtl/i2stx_smpbuf.sv
// Two-stage sample store: a staging pair filled by the valid/ready port and
// the playing pair used by the shifter. On 'load' (start of a frame) the
// staged pair moves to play, or zeros play and the sticky underrun flag sets.
// 'src_*' gives the pair the bit mapper must use in the current cycle.
module i2stx_smpbuf
    import i2stx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    output logic             in_ready,
    input  logic             load,
    input  logic             urun_clr,
    output logic [SMP_W-1:0] src_left,
    output logic [SMP_W-1:0] src_right,
    output logic             hold_left_lsb,
    output logic             hold_right_lsb,
    output logic             urun
);
    logic [SMP_W-1:0] nxt_l, nxt_r, cur_l, cur_r;
    logic             nxt_v, fire;

    assign in_ready = run && !nxt_v;
    assign fire     = in_valid && in_ready;

    // staging register: filled by a handshake, emptied by a frame load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_v <= 1'b0;
            nxt_l <= '0;
            nxt_r <= '0;
        end else if (!run) begin
            nxt_v <= 1'b0;
        end else if (fire) begin
            nxt_l <= in_left;
            nxt_r <= in_right;
            nxt_v <= 1'b1;
        end else if (load) begin
            nxt_v <= 1'b0;
        end
    end

    // playing register: takes the staged pair or silence at each frame start
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cur_l <= '0;
            cur_r <= '0;
        end else if (load) begin
            cur_l <= nxt_v ? nxt_l : '0;
            cur_r <= nxt_v ? nxt_r : '0;
        end
    end

    // underrun flag: set by an empty load, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)                       urun <= 1'b0;
        else if (run && load && !nxt_v)   urun <= 1'b1;
        else if (urun_clr)                urun <= 1'b0;
    end

    assign src_left       = !load ? cur_l : (nxt_v ? nxt_l : '0);
    assign src_right      = !load ? cur_r : (nxt_v ? nxt_r : '0);
    assign hold_left_lsb  = cur_l[0];
    assign hold_right_lsb = cur_r[0];
endmodule

// File: rtl/i2stx_slotmap.sv
// Combinational bit mapper: for the slot about to be emitted, picks the data
// bit and the word-select level from the format, data length and slot width.
// Assumes slot < 2*slot width. Unknown format codes map as standard I2S.
module i2stx_slotmap
    import i2stx_pkg::*;
#(
    parameter int SYNC_LEN = 13
) (
    input  logic [2:0]        fmt,
    input  logic [1:0]        len_sel,
    input  logic              wide,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SMP_W-1:0]  src_left,
    input  logic [SMP_W-1:0]  src_right,
    input  logic              spill_left,
    input  logic              spill_right,
    output logic              sd_bit,
    output logic              ws_bit
);
    logic [6:0]       flen, dlen, pos, off, s7, nx7, last;
    logic             ch;
    logic [SMP_W-1:0] word, aligned;
    logic [4:0]       idx;

    // decode lengths, slot position and the MSB-aligned data word
    always_comb begin
        flen = wide ? 7'd32 : 7'd16;
        case (len_sel)
            2'd0:    dlen = 7'd16;
            2'd1:    dlen = 7'd24;
            default: dlen = 7'd32;
        endcase
        s7      = {1'b0, slot};
        last    = (flen << 1) - 7'd1;
        nx7     = (s7 == last) ? 7'd0 : s7 + 7'd1;
        ch      = (s7 >= flen);
        pos     = ch ? (s7 - flen) : s7;
        off     = flen - dlen;
        word    = ch ? src_right : src_left;
        aligned = word << (7'(SMP_W) - dlen);
    end

    // data bit selection per format
    always_comb begin
        sd_bit = 1'b0;
        idx    = '0;
        case (fmt)
            FMT_LJ, FMT_PCM_S, FMT_PCM_L: begin
                if (pos < dlen) begin
                    idx    = 5'(7'd31 - pos);
                    sd_bit = aligned[idx];
                end
            end
            FMT_RJ: begin
                if (pos >= off) begin
                    idx    = 5'(7'd31 - (pos - off));
                    sd_bit = aligned[idx];
                end
            end
            default: begin
                if (pos == 7'd0) begin
                    sd_bit = (dlen == flen) ? (ch ? spill_left : spill_right) : 1'b0;
                end else if ((pos - 7'd1) < dlen) begin
                    idx    = 5'(7'd32 - pos);
                    sd_bit = aligned[idx];
                end
            end
        endcase
    end

    // word-select level per format
    always_comb begin
        case (fmt)
            FMT_LJ, FMT_RJ: ws_bit = ch;
            FMT_PCM_S:      ws_bit = (s7 == last);
            FMT_PCM_L:      ws_bit = (s7 < 7'(SYNC_LEN));
            default:        ws_bit = (nx7 >= flen);
        endcase
    end
endmodule

// File: rtl/i2s_audio_tx.sv
// Top of the serial audio transmitter in bus-controller mode. Ties the clock
// generator, sample store and bit mapper to a slot sequencer that registers
// sd/ws on each falling bit-clock event. Assumes static configuration while
// tx_en is high; tx_en low resets all transmit state to idle.
module i2s_audio_tx
    import i2stx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int SYNC_LEN = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic [2:0]       fmt_sel,
    input  logic [1:0]       len_sel,
    input  logic             frame_wide,
    input  logic             bclk_inv,
    input  logic             mclk_on,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_left,
    input  logic [SMP_W-1:0] smp_right,
    output logic             smp_ready,
    input  logic             urun_clr,
    output logic             bclk,
    output logic             ws,
    output logic             sd,
    output logic             mclk,
    output logic             urun
);
    logic              wide_eff, bclk_lvl, mclk_lvl, fall_evt, load;
    logic [SLOT_W-1:0] slot_q, nslot, last_slot;
    logic              live_q, sd_q, ws_q, mclk_q;
    logic [SMP_W-1:0]  src_l, src_r;
    logic              hold_l, hold_r, sd_bit, ws_bit;

    assign wide_eff  = frame_wide || (len_sel != 2'd0);
    assign last_slot = wide_eff ? SLOT_W'(63) : SLOT_W'(31);
    assign nslot     = !live_q ? '0 : ((slot_q == last_slot) ? '0 : slot_q + 1'b1);
    assign load      = fall_evt && (nslot == '0);

    i2stx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tx_en),
        .wide     (wide_eff),
        .div      (clk_div),
        .bclk_lvl (bclk_lvl),
        .mclk_lvl (mclk_lvl),
        .fall_evt (fall_evt)
    );

    i2stx_smpbuf u_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .run            (tx_en),
        .in_valid       (smp_valid),
        .in_left        (smp_left),
        .in_right       (smp_right),
        .in_ready       (smp_ready),
        .load           (load),
        .urun_clr       (urun_clr),
        .src_left       (src_l),
        .src_right      (src_r),
        .hold_left_lsb  (hold_l),
        .hold_right_lsb (hold_r),
        .urun           (urun)
    );

    i2stx_slotmap #(.SYNC_LEN(SYNC_LEN)) u_map (
        .fmt         (fmt_sel),
        .len_sel     (len_sel),
        .wide        (wide_eff),
        .slot        (nslot),
        .src_left    (src_l),
        .src_right   (src_r),
        .spill_left  (hold_l),
        .spill_right (hold_r),
        .sd_bit      (sd_bit),
        .ws_bit      (ws_bit)
    );

    // slot sequencer: advance one slot and launch sd/ws at each falling event
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            slot_q <= '0;
            live_q <= 1'b0;
            sd_q   <= 1'b0;
            ws_q   <= 1'b0;
        end else if (fall_evt) begin
            slot_q <= nslot;
            live_q <= 1'b1;
            sd_q   <= sd_bit;
            ws_q   <= ws_bit;
        end
    end

    // master clock output register, gated by enable
    always_ff @(posedge clk) begin
        if (!rst_n) mclk_q <= 1'b0;
        else        mclk_q <= tx_en && mclk_on && mclk_lvl;
    end

    assign bclk = bclk_lvl ^ bclk_inv;
    assign sd   = sd_q;
    assign ws   = ws_q;
    assign mclk = mclk_q;
endmodule

// File: rtl/i2stx_checker.sv
// Protocol checker for the serial audio transmitter, bound to the top.
// Assumes configuration inputs are static while tx_en is high.
module i2stx_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic bclk_inv,
    input logic mclk_on,
    input logic smp_valid,
    input logic smp_ready,
    input logic urun_clr,
    input logic bclk,
    input logic ws,
    input logic sd,
    input logic mclk,
    input logic urun
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en)) |-> (!sd && !ws && !mclk && !smp_ready && (bclk == bclk_inv))); // R1

    AST_MCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclk_on && !$past(mclk_on)) |-> !mclk); // R3

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $stable(bclk_inv) && !$stable(sd))
        |-> ($past(bclk ^ bclk_inv) && !(bclk ^ bclk_inv))); // R4

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $stable(bclk_inv) && !$stable(ws))
        |-> ($past(bclk ^ bclk_inv) && !(bclk ^ bclk_inv))); // R4

    AST_ONE_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready); // R11

    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !urun_clr) |=> urun); // R12
endmodule

bind i2s_audio_tx i2stx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .bclk_inv  (bclk_inv),
    .mclk_on   (mclk_on),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .urun_clr  (urun_clr),
    .bclk      (bclk),
    .ws        (ws),
    .sd        (sd),
    .mclk      (mclk),
    .urun      (urun)
);

// File: tb/tb_i2s_audio_tx.sv
// Scoreboard bench: the driver builds the expected serial frame of each pushed
// pair and queues it; the monitor pops one item per bit-clock rising edge.
module tb_i2s_audio_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [2:0]  fmt_sel = 3'd0;
    logic [1:0]  len_sel = 2'd0;
    logic        frame_wide = 1'b0;
    logic        bclk_inv = 1'b0;
    logic        mclk_on = 1'b0;
    logic [7:0]  clk_div = 8'd0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_left = '0;
    logic [31:0] smp_right = '0;
    logic        smp_ready;
    logic        urun_clr = 1'b0;
    logic        bclk, ws, sd, mclk, urun;

    always #5 clk = ~clk;

    i2s_audio_tx dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fmt_sel(fmt_sel),
        .len_sel(len_sel), .frame_wide(frame_wide), .bclk_inv(bclk_inv),
        .mclk_on(mclk_on), .clk_div(clk_div), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .smp_ready(smp_ready),
        .urun_clr(urun_clr), .bclk(bclk), .ws(ws), .sd(sd), .mclk(mclk),
        .urun(urun)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [1:0] expq[$];
    string      cur_tag = "R1";
    int         r4_bad = 0;
    logic       carry = 1'b0;

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    // monitor: R4 edge alignment and scoreboard compare at bit-clock rises
    logic raw_p = 1'b0, sd_p = 1'b0, ws_p = 1'b0, en_p = 1'b0;
    always @(negedge clk) begin
        logic raw;
        logic [1:0] e;
        raw = bclk ^ bclk_inv;
        if (tx_en && en_p && ((sd != sd_p) || (ws != ws_p)) && !(raw_p && !raw))
            r4_bad++;
        if (raw && !raw_p && (expq.size() > 0)) begin
            e = expq.pop_front();
            check(cur_tag, "ws/sd pair", {ws, sd}, e);
        end
        raw_p = raw; sd_p = sd; ws_p = ws; en_p = tx_en;
    end

    // builds one frame of expected {ws,sd} items from the requirements
    task automatic add_frame(input logic [31:0] l, input logic [31:0] r);
        int F, D, pos;
        logic b, nc;
        logic [63:0] sdv, wsv;
        D = (len_sel == 2'd0) ? 16 : (len_sel == 2'd1) ? 24 : 32;
        F = (frame_wide || len_sel != 2'd0) ? 32 : 16;
        sdv = '0; wsv = '0; nc = 1'b0;
        sdv[0] = carry;
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < D; k++) begin
                b = (c == 1) ? r[D-1-k] : l[D-1-k];
                case (fmt_sel)
                    3'd1, 3'd3, 3'd4: pos = c*F + k;
                    3'd2:             pos = c*F + (F - D) + k;
                    default:          pos = c*F + 1 + k;
                endcase
                if (pos == 2*F) nc = b;
                else            sdv[pos] = b;
            end
        end
        for (int s = 0; s < 2*F; s++) begin
            case (fmt_sel)
                3'd1, 3'd2: wsv[s] = (s >= F);
                3'd3:       wsv[s] = (s == 2*F - 1);
                3'd4:       wsv[s] = (s < 13);
                default:    wsv[s] = (((s + 1) % (2*F)) >= F);
            endcase
        end
        for (int s = 0; s < 2*F; s++) expq.push_back({wsv[s], sdv[s]});
        carry = nc;
    endtask

    task automatic push(input logic [31:0] l, input logic [31:0] r);
        @(negedge clk);
        while (!smp_ready) @(negedge clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // R2/R3: frame length, bit-clock count and master-clock count per frame
    task automatic measure(input string tag);
        int cyc, mr, br, F;
        logic prev, mp, bp, raw;
        F = (frame_wide || len_sel != 2'd0) ? 32 : 16;
        prev = ws;
        while (1) begin
            @(negedge clk);
            if (ws && !prev) break;
            prev = ws;
        end
        cyc = 0; mr = 0; br = 0; mp = mclk; bp = bclk ^ bclk_inv; prev = ws;
        while (1) begin
            @(negedge clk);
            raw = bclk ^ bclk_inv;
            cyc++;
            if (mclk && !mp) mr++;
            if (raw && !bp) br++;
            mp = mclk; bp = raw;
            if (ws && !prev) break;
            prev = ws;
        end
        check({tag, " R2"}, "clk cycles per frame", cyc, 512 * (int'(clk_div) + 1));
        check({tag, " R2"}, "bit clocks per frame", br, 2 * F);
        check({tag, " R3"}, "mclk periods per frame", mr, mclk_on ? 256 : 0);
    endtask

    task automatic run_test(input int fmt, input int len, input bit wide, input bit inv,
                            input bit mon, input int div, input int nfr, input string tag);
        logic [31:0] l, r;
        @(negedge clk);
        tx_en = 1'b0;
        repeat (3) @(negedge clk);
        fmt_sel = 3'(fmt); len_sel = 2'(len); frame_wide = wide;
        bclk_inv = inv; mclk_on = mon; clk_div = 8'(div);
        @(negedge clk);
        check("R1/R10", "idle bclk", bclk, inv);
        check("R1", "idle sd/ws", {ws, sd}, 0);
        check("R1", "idle ready", smp_ready, 0);
        carry = 1'b0;
        r4_bad = 0;
        cur_tag = tag;
        expq.push_back(2'b00);
        tx_en = 1'b1;
        for (int i = 0; i < nfr; i++) begin
            l = 32'hA5C3_0F17 ^ (32'(i + 1) * 32'h0123_4567) ^ (32'(fmt) << 27);
            r = ~l + 32'(len * 7 + i);
            push(l, r);
            add_frame(l, r);
            check("R11", "ready after accept", smp_ready, 0);
        end
        check("R12", "no underrun while fed", urun, 0);
        add_frame('0, '0);
        while (expq.size() > 0) @(negedge clk);
        check("R12", "underrun after starvation", urun, 1);
        check("R4", "sd/ws moves off falling edge", r4_bad, 0);
        measure(tag);
        @(negedge clk); urun_clr = 1'b1;
        @(negedge clk); urun_clr = 1'b0;
        check("R12", "underrun cleared", urun, 0);
        tx_en = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset sd", sd, 0);
        check("R1", "reset ws", ws, 0);
        check("R1", "reset mclk", mclk, 0);
        check("R1", "reset bclk", bclk, 0);
        check("R1", "reset urun", urun, 0);
        check("R1", "reset ready", smp_ready, 0);

        run_test(0, 0, 1'b0, 1'b0, 1'b1, 0, 3, "R5 std 16/16");
        run_test(0, 2, 1'b1, 1'b0, 1'b0, 0, 3, "R5/R9 std 32/32 spill");
        run_test(0, 1, 1'b1, 1'b0, 1'b1, 1, 3, "R5/R9 std 24/32");
        run_test(1, 1, 1'b1, 1'b1, 1'b1, 0, 3, "R6/R10 lj 24 inverted");
        run_test(1, 0, 1'b0, 1'b0, 1'b0, 0, 3, "R6/R9 lj 16/16");
        run_test(2, 1, 1'b0, 1'b0, 1'b1, 0, 3, "R7/R9 rj 24 forced wide");
        run_test(2, 0, 1'b1, 1'b0, 1'b1, 0, 3, "R7/R9 rj 16 in 32");
        run_test(3, 0, 1'b0, 1'b0, 1'b1, 0, 3, "R8 pcm short 16");
        run_test(4, 3, 1'b1, 1'b0, 1'b1, 2, 3, "R8/R9 pcm long 32");
        run_test(5, 0, 1'b1, 1'b0, 1'b0, 0, 2, "R8 code 5 as std");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule